// File: doc/BRIEF.md
# Grouped shared interrupt multiplexer

This block collects up to thirty-two level-sensitive peripheral interrupt lines and folds them into at most four group lines, each of which goes to one input of a parent interrupt controller. Every group owns a contiguous slice of bit positions. Sources are numbered as one flat index from 0 upward, and source number n always sits at bit n.

All groups share a single 32-bit enable register and a single 32-bit status register. A group built without enable control passes its pending bits straight to its output, and its slice of the enable register is not writable. Status is a live copy of the source levels. There is no clear register: a bit falls when its peripheral lets go of the line.

Software uses a small register port. It writes enables at offset 0x54 and reads raw pending bits at offset 0x58, inside a 4 KB window. The group slices and the choice of groups that have enables are fixed at elaboration. A parameter check rejects overlapping slices and more than four groups.

Top module: `irqmux_top`

## Requirements
- R1: After reset, the enable register reads 0x00000000 and every group output is low.
- R2: A write at offset 0x54 stores the written bits at positions that belong to a group with enable control. With the default slices (group 0 on bits 0..8, group 1 on bits 9..15, group 2 on bits 16..23, all with enables) this is mask 0x00FFFFFF. Every other bit reads back as zero.
- R3: A read at offset 0x58 returns the raw source levels, without enable masking, for bits that belong to any group (default mask 0x0FFFFFFF). Bits outside all groups read zero, and a read at any offset other than 0x54 or 0x58 returns zero.
- R4: Status is level-sensitive. It shows a source level one clock edge after the source changes, and it drops when the source deasserts, without any clear action.
- R5: A group output is the registered OR over the group's slice of status AND enable. It rises two clock edges after its source rises while the enable bit is set.
- R6: A group output ignores pending bits that lie outside its own slice.
- R7: A group without enable control (default group 3 on bits 24..27) drives its output from its pending bits, whatever value the enable register holds.
- R8: Clearing an enable bit while its source stays high drops the group output.
- R9: Writes at offset 0x58 or at any other offset leave the enable and status registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | 32 | Level interrupt lines, source n on bit n |
| reg_addr | input | 12 | Byte offset in the register window |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| grp_irq | output | 4 | One interrupt line per group toward the parent controller |

## Verification
The sources are driven one at a time: first inside a group's slice, then in another group's slice, then only on unused high bits. This separates correct slice decoding from leakage between groups, and masked bits from raw status. The enable register is driven with all-ones, with zero and with single-group values. These show apart the writable mask, the group that has no enable, and the gating of a live source when its enable is removed. One sequence samples a single source rise after one edge and again after two, which pins down the capture latency and the output register. Several groups are also raised together, so that independent outputs are confirmed.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ADDR_W     = 12;
    localparam int unsigned MAX_GROUPS = 4;

    localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h054;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h058;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        word_t             wdata;
    } reg_req_t;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_STATUS = 2'd2
    } reg_sel_e;

    function automatic word_t range_mask(input int unsigned lo, input int unsigned hi);
        word_t m;
        m = '0;
        for (int unsigned i = 0; i < DATA_W; i++) begin
            m[i] = (i >= lo) && (i <= hi);
        end
        return m;
    endfunction

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        if (a == OFS_ENABLE) return SEL_ENABLE;
        if (a == OFS_STATUS) return SEL_STATUS;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/irqmux_capture.sv
module irqmux_capture
    import irqmux_pkg::*;
#(
    parameter word_t STAT_MASK = '1
) (
    input  logic  clk,
    input  logic  rst,
    input  word_t src,
    output word_t status
);

    word_t st_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= src & STAT_MASK;
    end

    assign status = st_q;

    // R4: status tracks the sampled level of each source, no sticky bits
    p_level_track_r4: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (st_q == ($past(src) & STAT_MASK)));

endmodule

// File: rtl/irqmux_regs.sv
module irqmux_regs
    import irqmux_pkg::*;
#(
    parameter word_t EN_MASK   = '1,
    parameter word_t STAT_MASK = '1
) (
    input  logic     clk,
    input  logic     rst,
    input  reg_req_t req,
    input  word_t    status,
    output word_t    enable,
    output word_t    rdata
);

    word_t    en_q;
    reg_sel_e sel;
    logic     en_wr;

    assign sel   = decode(req.addr);
    assign en_wr = req.wr && (sel == SEL_ENABLE);

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (en_wr) en_q <= req.wdata & EN_MASK;
    end

    always_comb begin
        unique case (sel)
            SEL_ENABLE: rdata = en_q;
            SEL_STATUS: rdata = status & STAT_MASK;
            default:    rdata = '0;
        endcase
    end

    assign enable = en_q;

    // R2: a write at the enable offset lands, filtered by the writable mask
    p_enable_write_r2: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.addr == OFS_ENABLE) |=> (en_q == ($past(req.wdata) & EN_MASK)));

    // R9: no other access disturbs the enable register
    p_enable_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.addr == OFS_ENABLE) |=> $stable(en_q));

endmodule

// File: rtl/irqmux_group.sv
module irqmux_group
    import irqmux_pkg::*;
#(
    parameter int unsigned LO     = 0,
    parameter int unsigned HI     = 0,
    parameter bit          HAS_EN = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  word_t status,
    input  word_t enable,
    output logic  irq
);

    localparam word_t SLICE = range_mask(LO, HI);

    word_t gate;
    logic  any_q;

    generate
        if (HAS_EN) begin : g_gated
            assign gate = enable;
        end else begin : g_open
            assign gate = '1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) any_q <= 1'b0;
        else     any_q <= |(status & SLICE & gate);
    end

    assign irq = any_q;

    // R6: the output needs a pending bit inside the group's own slice
    p_needs_own_pending_r6: assert property (@(posedge clk) disable iff (rst)
        any_q |-> $past(|(status & SLICE)));

    generate
        if (HAS_EN) begin : g_chk_en
            // R8: with every enable of the slice cleared the output stays low
            p_gate_closed_r8: assert property (@(posedge clk) disable iff (rst)
                !$past(|(enable & SLICE)) |-> !any_q);
        end else begin : g_chk_open
            // R7: a group without enables fires on any pending bit
            p_open_fires_r7: assert property (@(posedge clk) disable iff (rst)
                $past(|(status & SLICE)) |-> any_q);
        end
    endgenerate

endmodule

// File: rtl/irqmux_top.sv
module irqmux_top
    import irqmux_pkg::*;
#(
    parameter int unsigned NUM_GROUPS             = 4,
    parameter int unsigned GRP_LO [MAX_GROUPS]    = '{0, 9, 16, 24},
    parameter int unsigned GRP_HI [MAX_GROUPS]    = '{8, 15, 23, 27},
    parameter bit          GRP_HAS_EN [MAX_GROUPS] = '{1'b1, 1'b1, 1'b1, 1'b0}
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DATA_W-1:0]     src_irq,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [NUM_GROUPS-1:0] grp_irq
);

    function automatic bit cfg_ok();
        word_t acc;
        word_t m;
        bit    ok;
        acc = '0;
        ok  = 1'b1;
        if (NUM_GROUPS == 0 || NUM_GROUPS > MAX_GROUPS) return 1'b0;
        for (int unsigned g = 0; g < NUM_GROUPS; g++) begin
            if (GRP_LO[g] > GRP_HI[g] || GRP_HI[g] >= DATA_W) begin
                ok = 1'b0;
            end else begin
                m = range_mask(GRP_LO[g], GRP_HI[g]);
                if ((acc & m) != '0) ok = 1'b0;
                acc = acc | m;
            end
        end
        return ok;
    endfunction

    function automatic word_t union_mask(input bit only_enabled);
        word_t acc;
        acc = '0;
        for (int unsigned g = 0; g < NUM_GROUPS && g < MAX_GROUPS; g++) begin
            if (!only_enabled || GRP_HAS_EN[g]) acc = acc | range_mask(GRP_LO[g], GRP_HI[g]);
        end
        return acc;
    endfunction

    localparam bit    CFG_VALID = cfg_ok();
    localparam word_t STAT_MASK = union_mask(1'b0);
    localparam word_t EN_MASK   = union_mask(1'b1);

    generate
        if (!CFG_VALID) begin : g_bad_cfg
            $error("irqmux_top: group slices overlap, exceed the word or exceed four groups");
        end
    endgenerate

    reg_req_t req;
    word_t    status;
    word_t    enable;

    assign req.wr    = reg_wr;
    assign req.addr  = reg_addr;
    assign req.wdata = reg_wdata;

    irqmux_capture #(.STAT_MASK(STAT_MASK)) u_capture (
        .clk    (clk),
        .rst    (rst),
        .src    (src_irq),
        .status (status)
    );

    irqmux_regs #(.EN_MASK(EN_MASK), .STAT_MASK(STAT_MASK)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .status (status),
        .enable (enable),
        .rdata  (reg_rdata)
    );

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            irqmux_group #(
                .LO     (GRP_LO[g]),
                .HI     (GRP_HI[g]),
                .HAS_EN (GRP_HAS_EN[g])
            ) u_group (
                .clk    (clk),
                .rst    (rst),
                .status (status),
                .enable (enable),
                .irq    (grp_irq[g])
            );
        end
    endgenerate

    // R1: outputs are quiet in the cycle after a reset edge
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (grp_irq == '0));

    // R3: bits outside every group never show in a status read
    p_status_unused_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_STATUS) |-> ((reg_rdata & ~STAT_MASK) == '0));

endmodule

// File: tb/test_irqmux_top.sv
module test_irqmux_top;
    import irqmux_pkg::*;

    localparam word_t EN_W   = 32'h00FF_FFFF;
    localparam word_t ST_W   = 32'h0FFF_FFFF;
    localparam word_t G0     = 32'h0000_01FF;
    localparam word_t G1     = 32'h0000_FE00;
    localparam word_t G2     = 32'h00FF_0000;
    localparam word_t G3     = 32'h0F00_0000;

    typedef struct {
        string      rid;
        logic [3:0] irq;
        word_t      rdata;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    word_t       src_irq = '0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    word_t       reg_wdata = '0;
    word_t       reg_rdata;
    logic [3:0]  grp_irq;

    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    item_t sb [$];
    word_t m_en   = '0;
    word_t m_src  = '0;

    always #10 clk = ~clk;

    irqmux_top i_irqmux_top (
        .clk       (clk),
        .rst       (rst),
        .src_irq   (src_irq),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .grp_irq   (grp_irq)
    );

    function automatic logic [3:0] exp_irq();
        logic [3:0] e;
        e[0] = |(m_src & G0 & m_en);
        e[1] = |(m_src & G1 & m_en);
        e[2] = |(m_src & G2 & m_en);
        e[3] = |(m_src & G3);
        return e;
    endfunction

    function automatic word_t exp_rd(input logic [11:0] a);
        if (a == 12'h054) return m_en;
        if (a == 12'h058) return m_src & ST_W;
        return '0;
    endfunction

    task automatic push(input string rid, input logic [3:0] irq, input word_t rd);
        item_t it;
        it.rid = rid; it.irq = irq; it.rdata = rd;
        sb.push_back(it);
    endtask

    task automatic wr_reg(input logic [11:0] a, input word_t d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        if (a == 12'h054) m_en = d & EN_W;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic drive_src(input word_t v);
        @(negedge clk);
        src_irq = v;
        m_src   = v;
    endtask

    task automatic expect_at(input string rid, input logic [11:0] a);
        @(negedge clk);
        reg_addr = a;
        @(posedge clk);
        @(posedge clk);
        #1;
        push(rid, exp_irq(), exp_rd(a));
    endtask

    // monitor: compare queued expectations a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_run++;
                if (grp_irq !== it.irq || reg_rdata !== it.rdata) begin
                    n_fail++;
                    $display("FAIL %s: irq=%b rdata=%h expected irq=%b rdata=%h",
                             it.rid, grp_irq, reg_rdata, it.irq, it.rdata);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        expect_at("R1", 12'h054);

        // R2: only enable-capable slices are writable
        wr_reg(12'h054, 32'hFFFF_FFFF);
        expect_at("R2", 12'h054);
        wr_reg(12'h054, 32'h0000_0000);
        expect_at("R2", 12'h054);

        // R3: raw status read, not masked by enable
        drive_src(32'h0000_0008);
        expect_at("R3", 12'h058);
        drive_src(32'hF000_0000);
        expect_at("R3", 12'h058);
        drive_src(32'h0000_0008);
        expect_at("R3", 12'h100);

        // R5: enabled source in group 0 raises group 0
        wr_reg(12'h054, 32'h0000_01FF);
        expect_at("R5", 12'h058);

        // R6: a source in group 1 does not touch group 0
        drive_src(32'h0000_0400);
        expect_at("R6", 12'h058);

        // R7: group 3 fires with no enable at all
        wr_reg(12'h054, 32'h0000_0000);
        drive_src(32'h0200_0000);
        expect_at("R7", 12'h054);
        wr_reg(12'h054, 32'hFFFF_FFFF);
        expect_at("R7", 12'h054);

        // R4 and R5 latency: one edge to status, two edges to the output
        wr_reg(12'h054, 32'h0000_01FF);
        drive_src(32'h0000_0000);
        expect_at("R4", 12'h058);
        @(negedge clk);
        reg_addr = 12'h058;
        src_irq  = 32'h0000_0001;
        m_src    = 32'h0000_0001;
        @(posedge clk);
        #1;
        push("R4", 4'b0000, 32'h0000_0001);
        @(posedge clk);
        #1;
        push("R5", 4'b0001, 32'h0000_0001);

        // R4: status falls with the source, no clear needed
        drive_src(32'h0000_0000);
        expect_at("R4", 12'h058);

        // R8: removing the enable drops a live source's group output
        drive_src(32'h0000_0001);
        expect_at("R8", 12'h058);
        wr_reg(12'h054, 32'h0000_0000);
        expect_at("R8", 12'h058);

        // R9: writes elsewhere change nothing
        wr_reg(12'h054, 32'h0001_0200);
        drive_src(32'h0001_0000);
        wr_reg(12'h058, 32'hFFFF_FFFF);
        expect_at("R9", 12'h054);
        wr_reg(12'h200, 32'hFFFF_FFFF);
        expect_at("R9", 12'h054);
        expect_at("R9", 12'h058);

        // R5/R6: several groups at once, each independent
        wr_reg(12'h054, 32'h00FF_FFFF);
        drive_src(32'h0401_0201);
        expect_at("R5", 12'h058);
        drive_src(32'h0000_8000);
        expect_at("R6", 12'h058);

        @(posedge clk);
        #6;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule